// File: doc/BRIEF.md
# Interrupt Mask Set/Clear Controller

This block keeps two 32-bit vectors, an interrupt cause vector and an enable mask, behind a small register read/write bus. Software changes the mask only through two write-one registers. One register enables the mask bits written as 1 and the other disables them. Writing zeros to either register has no effect. Reading the mask-set register returns the current mask. A third write-one register forces cause bits so that software can test the interrupt path. Per-source hardware event pulses also set cause bits. Reading the cause register returns the cause vector and clears it.

The block drives one level-sensitive interrupt line toward the host bus. The line is high when any cause bit is set and its mask bit is also set. The line is registered, so it follows the vectors one clock later. The vectors are sparse. Bits 3:0 hold receive-queue sources, bits 11:8 hold transmit-queue sources, bit 30 holds a timer source and bit 31 holds a general "other" source. All remaining bits are reserved.

Each bus cycle is decoded into one named access kind: none, mask-set write, mask-clear write, cause-set write, mask read, cause read, or other read. If a write and a read arrive in the same cycle, the write is decoded and the read is dropped. Read data is registered. It appears one cycle after the read strobe and then holds until the next read.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset the mask is 0x8000_0000 (only bit 31 enabled), the cause vector is 0 and irq_o is 0.
- R2: A write to the mask-set register (byte offset 0x1524) sets every valid mask bit written as 1. Bits written as 0 keep their value.
- R3: A write to the mask-clear register (offset 0x1528) clears every mask bit written as 1. Reading that register returns 0.
- R4: A read of the mask-set register returns the current mask.
- R5: The valid mask bits are 3:0, 11:8, 30 and 31 (0xC000_0F0F). All other mask bits read as 0 and ignore writes.
- R6: A write to the cause-set register (offset 0x1514) sets the cause bits written as 1 within 0x4000_0F0F. Bit 31 and the reserved bits are ignored.
- R7: A 1 on evt_i for one cycle sets the matching cause bit when that bit lies within 0xC000_0F0F. Event bits outside that set are ignored.
- R8: A read of the cause register (offset 0x1510) returns the cause vector and clears it. An event in the same cycle as the read stays set after the clear.
- R9: irq_o equals the OR of (cause AND mask) as it stood one clock earlier.
- R10: bus_rdata_o is updated one cycle after bus_rd_i and holds between reads. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one cycle |
| bus_rd_i | input | 1 | Read strobe, one cycle |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| evt_i | input | 32 | Per-source event pulses |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The bench builds the block with its default parameters: four receive-queue and four transmit-queue sources and a 16-bit address. With these values the offsets and the valid-bit patterns 0xC000_0F0F and 0x4000_0F0F are fixed constants that the directed checks can test against. Directed checks cover the reset mask, writes of all ones to reach the reserved holes, writes of zeros to the set register, and an event that lands in the same cycle as a cause read. A random phase then mixes all access kinds with event pulses and compares the design with a behavioural model on every clock.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
    localparam int DATA_W = 32;
    localparam int RXQ_N  = 4;
    localparam int TXQ_N  = 4;
    localparam int TX_LSB = 8;
    localparam int TMR_BIT = 30;
    localparam int OTH_BIT = 31;

    localparam logic [DATA_W-1:0] RX_BITS  = DATA_W'((64'd1 << RXQ_N) - 64'd1);
    localparam logic [DATA_W-1:0] TX_BITS  = DATA_W'(((64'd1 << TXQ_N) - 64'd1) << TX_LSB);
    localparam logic [DATA_W-1:0] TMR_ONE  = DATA_W'(64'd1 << TMR_BIT);
    localparam logic [DATA_W-1:0] OTH_ONE  = DATA_W'(64'd1 << OTH_BIT);

    localparam logic [DATA_W-1:0] MASK_VALID = RX_BITS | TX_BITS | TMR_ONE | OTH_ONE;
    localparam logic [DATA_W-1:0] CSET_VALID = RX_BITS | TX_BITS | TMR_ONE;
    localparam logic [DATA_W-1:0] EVT_VALID  = MASK_VALID;
    localparam logic [DATA_W-1:0] MASK_RESET = OTH_ONE;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_MASK_SET_WR,
        ACC_MASK_CLR_WR,
        ACC_CAUSE_SET_WR,
        ACC_MASK_RD,
        ACC_CAUSE_RD,
        ACC_OTHER_RD
    } acc_e;
endpackage

// File: rtl/irq_acc_decode.sv
module irq_acc_decode
    import irq_mask_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] OFS_CAUSE    = 16'h1510,
    parameter logic [ADDR_W-1:0] OFS_CAUSE_SET = 16'h1514,
    parameter logic [ADDR_W-1:0] OFS_MASK_SET = 16'h1524,
    parameter logic [ADDR_W-1:0] OFS_MASK_CLR = 16'h1528
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    output acc_e              acc
);
    // write takes precedence over a read in the same cycle
    always_comb begin
        acc = ACC_NONE;
        if (wr) begin
            if (addr == OFS_MASK_SET)       acc = ACC_MASK_SET_WR;
            else if (addr == OFS_MASK_CLR)  acc = ACC_MASK_CLR_WR;
            else if (addr == OFS_CAUSE_SET) acc = ACC_CAUSE_SET_WR;
        end else if (rd) begin
            if (addr == OFS_MASK_SET)       acc = ACC_MASK_RD;
            else if (addr == OFS_CAUSE)     acc = ACC_CAUSE_RD;
            else                            acc = ACC_OTHER_RD;
        end
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_mask_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask_q
);
    logic [DATA_W-1:0] mask_d;

    always_comb begin
        mask_d = mask_q;
        if (set_en) mask_d = mask_q | (wdata & MASK_VALID);
        if (clr_en) mask_d = mask_d & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= MASK_RESET;
        else        mask_q <= mask_d;
    end

    p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_en && !clr_en |=> ((mask_q & $past(wdata & MASK_VALID)) == $past(wdata & MASK_VALID)));
    p_zero_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_en && !clr_en |=> (($past(mask_q) & ~mask_q) == '0));
    p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !set_en && !clr_en |=> $stable(mask_q));
    p_clear_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((mask_q & $past(wdata)) == '0));
    p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q & ~MASK_VALID) == '0);
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
    import irq_mask_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_clr,
    input  logic              set_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] evt,
    output logic [DATA_W-1:0] cause_q
);
    logic [DATA_W-1:0] cause_d;

    // clear first, then OR in sets so that an event beats a clear
    always_comb begin
        cause_d = rd_clr ? '0 : cause_q;
        if (set_en) cause_d = cause_d | (wdata & CSET_VALID);
        cause_d = cause_d | (evt & EVT_VALID);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= cause_d;
    end

    p_evt_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        |(evt & EVT_VALID) |=> ((cause_q & $past(evt & EVT_VALID)) == $past(evt & EVT_VALID)));
    p_cset_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((cause_q & $past(wdata & CSET_VALID)) == $past(wdata & CSET_VALID)));
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr && !set_en && (evt == '0) |=> (cause_q == '0));
    p_cause_rsvd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q & ~EVT_VALID) == '0);
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
    import irq_mask_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    input  logic [31:0]       evt_i,
    output logic              irq_o
);
    acc_e              acc;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] cause_q;
    logic [DATA_W-1:0] rd_mux;

    irq_acc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr   (bus_wr_i),
        .rd   (bus_rd_i),
        .addr (bus_addr_i),
        .acc  (acc)
    );

    irq_mask_reg u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (acc == ACC_MASK_SET_WR),
        .clr_en (acc == ACC_MASK_CLR_WR),
        .wdata  (bus_wdata_i),
        .mask_q (mask_q)
    );

    irq_cause_reg u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_clr  (acc == ACC_CAUSE_RD),
        .set_en  (acc == ACC_CAUSE_SET_WR),
        .wdata   (bus_wdata_i),
        .evt     (evt_i),
        .cause_q (cause_q)
    );

    always_comb begin
        rd_mux = '0;
        unique case (acc)
            ACC_MASK_RD:  rd_mux = mask_q;
            ACC_CAUSE_RD: rd_mux = cause_q;
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata_o <= '0;
            irq_o       <= 1'b0;
        end else begin
            if (acc inside {ACC_MASK_RD, ACC_CAUSE_RD, ACC_OTHER_RD})
                bus_rdata_o <= rd_mux;
            irq_o <= |(cause_q & mask_q);
        end
    end

    p_irq_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|(cause_q & mask_q)));
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> $stable(bus_rdata_o));
    p_mask_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_i && !bus_wr_i && (bus_addr_i == 16'h1524) |=> (bus_rdata_o == $past(mask_q)));
endmodule

// File: tb/irq_mask_ctrl_tb.sv
module irq_mask_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] A_CAUSE = 16'h1510;
    localparam logic [15:0] A_CSET  = 16'h1514;
    localparam logic [15:0] A_MSET  = 16'h1524;
    localparam logic [15:0] A_MCLR  = 16'h1528;

    logic clk = 0, rst_n = 0;
    logic wr = 0, rd = 0;
    logic [15:0] addr = 0;
    logic [31:0] wdata = 0, evt = 0, rdata;
    logic irq;

    int errors = 0, checks = 0;
    logic [31:0] m_mask, m_cause, m_rdata;
    logic m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_mask_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .evt_i(evt), .irq_o(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural reference, advanced once per rising edge
    task automatic model_edge();
        logic [31:0] nm, nc;
        m_irq = (m_cause & m_mask) != 0;
        nm = m_mask; nc = m_cause;
        if (wr) begin
            if (addr == A_MSET) nm = m_mask | (wdata & 32'hC000_0F0F);
            if (addr == A_MCLR) nm = m_mask & ~wdata;
            if (addr == A_CSET) nc = m_cause | (wdata & 32'h4000_0F0F);
        end else if (rd) begin
            if (addr == A_MSET)       m_rdata = m_mask;
            else if (addr == A_CAUSE) begin m_rdata = m_cause; nc = 0; end
            else                      m_rdata = 0;
        end
        nc = nc | (evt & 32'hC000_0F0F);
        m_mask = nm; m_cause = nc;
    endtask

    task automatic step(input logic w, input logic r, input logic [15:0] a,
                        input logic [31:0] d, input logic [31:0] e);
        wr = w; rd = r; addr = a; wdata = d; evt = e;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("R9 irq vs model", {31'd0, irq}, {31'd0, m_irq});
        check("R10 rdata vs model", rdata, m_rdata);
        wr = 0; rd = 0; evt = 0; wdata = 0;
    endtask

    task automatic idle(); step(0, 0, 0, 0, 0); endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_mask = 32'h8000_0000; m_cause = 0; m_rdata = 0; m_irq = 0;
        repeat (3) @(negedge clk);
        check("R1 irq at reset", {31'd0, irq}, 0);
        check("R1 rdata at reset", rdata, 0);
        rst_n = 1;
        @(negedge clk);

        step(0, 1, A_MSET, 0, 0);
        check("R1 R4 reset mask", rdata, 32'h8000_0000);
        step(0, 1, A_CAUSE, 0, 0);
        check("R1 reset cause", rdata, 0);

        step(1, 0, A_MSET, 32'hFFFF_FFFF, 0);
        step(0, 1, A_MSET, 0, 0);
        check("R2 R5 set all, reserved stay 0", rdata, 32'hC000_0F0F);
        step(1, 0, A_MSET, 32'h0, 0);
        step(0, 1, A_MSET, 0, 0);
        check("R2 zero write keeps mask", rdata, 32'hC000_0F0F);

        step(1, 0, A_MCLR, 32'h0000_0F00, 0);
        step(0, 1, A_MSET, 0, 0);
        check("R3 clear tx bits", rdata, 32'hC000_000F);
        step(0, 1, A_MCLR, 0, 0);
        check("R3 clear register reads 0", rdata, 0);
        step(0, 1, 16'h0400, 0, 0);
        check("R10 unmapped read 0", rdata, 0);

        step(1, 0, A_CSET, 32'hFFFF_FFFF, 0);
        idle();
        check("R9 irq after cause-set", {31'd0, irq}, 1);
        step(0, 1, A_CAUSE, 0, 0);
        check("R6 cause-set bits, bit31 ignored", rdata, 32'h4000_0F0F);
        step(0, 1, A_CAUSE, 0, 0);
        check("R8 cause cleared by read", rdata, 0);
        idle();
        check("R9 irq low after clear", {31'd0, irq}, 0);

        step(0, 0, 0, 0, 32'h8000_0000);
        check("R9 irq not yet high on event edge", {31'd0, irq}, 0);
        idle();
        check("R7 R9 irq one cycle after event", {31'd0, irq}, 1);

        step(0, 1, A_CAUSE, 0, 32'h0000_0001);
        check("R8 read returns pre-event cause", rdata, 32'h8000_0000);
        step(0, 1, A_CAUSE, 0, 0);
        check("R8 event in read cycle survives", rdata, 32'h0000_0001);

        step(0, 0, 0, 0, 32'h3FFF_F0F0);
        step(0, 1, A_CAUSE, 0, 0);
        check("R7 reserved events ignored", rdata, 0);

        step(1, 0, A_MCLR, 32'hFFFF_FFFF, 0);
        step(1, 0, A_CSET, 32'h0000_0001, 0);
        idle(); idle();
        check("R9 masked cause keeps irq low", {31'd0, irq}, 0);
        step(1, 0, A_MSET, 32'h0000_0001, 0);
        idle();
        check("R9 enabling mask raises irq", {31'd0, irq}, 1);

        for (int i = 0; i < 400; i++) begin
            int k = $urandom_range(0, 5);
            logic [31:0] d = $urandom();
            logic [31:0] e = ($urandom_range(0, 3) == 0) ? $urandom() : 32'h0;
            case (k)
                0: step(1, 0, A_MSET, d, e);
                1: step(1, 0, A_MCLR, d, e);
                2: step(1, 0, A_CSET, d & $urandom(), e);
                3: step(0, 1, A_MSET, 0, e);
                4: step(0, 1, A_CAUSE, 0, e);
                default: step(0, 0, 0, 0, e);
            endcase
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule